// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial controller read and write a byte-wide internal register space. A transaction begins when the controller pulls the active-low select line low. The controller then shifts in a 16-bit instruction: a direction bit followed by a 15-bit register address. One or more data bytes follow. While select stays low after the first byte, the transfer continues as a stream, and the block steps the register address after every byte. A configuration input chooses whether the address counts up or down.

All serial pins are oversampled by the system clock through a short synchronizer. The block therefore works in a single clock domain, and the serial clock must be several times slower than the system clock. A second configuration input chooses the pin arrangement. In 3-wire mode, read data goes back on the shared data line. In 4-wire mode, read data goes out on a dedicated output. On the register side, the block drives an address, a write byte, single-cycle write and read strobes, and a read-data input that is sampled in the strobe cycle. The registers themselves live outside this block.

Top module: `spi_reg_access`

## Requirements
- R1: While `spi_csn` is high, serial clock activity produces no `reg_wr` or `reg_rd` pulse and both output enables stay low.
- R2: The first 16 bits after `spi_csn` falls are sampled on rising `spi_sclk`, MSB first. Bit 15 is the direction (1 = read, 0 = write) and bits 14..0 are the address A14..A0. The first data byte uses that address.
- R3: In a write, each complete 8-bit data byte (D7 first) produces exactly one `reg_wr` pulse, with `reg_wdata` equal to that byte.
- R4: If `spi_csn` rises before the 8th bit of a write byte, that partial byte produces no `reg_wr`.
- R5: In a read, one `reg_rd` pulse is issued at the instruction address after A0 is sampled, before the next falling `spi_sclk`. `reg_rdata` is captured in that pulse cycle.
- R6: Read data is shifted out D7 first, and each bit changes on falling `spi_sclk`. The first bit (D7) appears on the falling edge that follows the A0 sample.
- R7: With `cfg_four_wire` = 0, read data appears on `sdio_o` with `sdio_oe` = 1, and `sdo_oe` stays 0.
- R8: With `cfg_four_wire` = 1, read data appears on `sdo_o` with `sdo_oe` = 1, and `sdio_oe` stays 0.
- R9: Both output enables stay low during the instruction phase and throughout a write transaction.
- R10: In streaming, each further byte uses the previous address +1 when `cfg_descend` = 0, or -1 when `cfg_descend` = 1. In a read, the next byte is fetched (one `reg_rd`) right after each byte's D0 is sampled, so an N-byte read issues N+1 read strobes.
- R11: The streaming address wraps modulo 2^15: 0x7FFF steps up to 0x0000, and 0x0000 steps down to 0x7FFF.
- R12: `reg_wr` and `reg_rd` are never high together, and each pulse lasts one clock cycle.
- R13: After reset, `reg_wr`, `reg_rd`, `sdio_oe` and `sdo_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_four_wire | input | 1 | 1 = read data on `sdo_o`, 0 = read data on shared line |
| cfg_descend | input | 1 | 1 = streaming address counts down, 0 = counts up |
| spi_sclk | input | 1 | Serial clock from controller |
| spi_csn | input | 1 | Active-low transaction select |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line driver enable |
| sdo_o | output | 1 | Dedicated read-data output value |
| sdo_oe | output | 1 | Dedicated read-data output enable |
| reg_addr | output | 15 | Register address |
| reg_wdata | output | 8 | Register write byte |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Register read byte, sampled while `reg_rd` is high |

## Verification
The bench uses the default parameters: a 15-bit address, 8-bit data and a two-stage synchronizer. With a 15-bit address, streams that start at 0x7FFE (counting up) and at 0x0001 or 0x0000 (counting down) cross the wrap boundary within a few bytes. The two-stage synchronizer gives an edge-to-output latency of about three clock cycles. That latency fits inside the half serial period of eight clock cycles that the bench uses, so falling-edge output timing and the read fetch deadline can be checked exactly.

// File: rtl/spi_acc_pkg.sv
`timescale 1ns/1ps
package spi_acc_pkg;

    localparam int ADDR_W_DEF = 15;
    localparam int DATA_W_DEF = 8;
    localparam int SYNC_DEF   = 2;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    // single-cycle events raised by the frame controller
    typedef struct packed {
        logic instr_done;
        logic byte_done;
    } frame_evt_t;

    // one oversampled snapshot of the serial pins
    typedef struct packed {
        logic sdi;
        logic csn;
        logic sclk;
    } pin_sample_t;

    localparam pin_sample_t PIN_IDLE = '{sdi: 1'b0, csn: 1'b1, sclk: 1'b0};

endpackage

// File: rtl/spi_edge_sync.sv
`timescale 1ns/1ps
module spi_edge_sync
    import spi_acc_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic sdi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic csn_act,
    output logic sdi_s
);
    localparam int LAST = STAGES - 1;

    pin_sample_t pipe [STAGES];
    logic        sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= PIN_IDLE;
            sclk_prev <= 1'b0;
        end else begin
            pipe[0] <= '{sdi: sdi_i, csn: csn_i, sclk: sclk_i};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            sclk_prev <= pipe[LAST].sclk;
        end
    end

    assign sclk_rise = pipe[LAST].sclk & ~sclk_prev;
    assign sclk_fall = ~pipe[LAST].sclk & sclk_prev;
    assign csn_act   = ~pipe[LAST].csn;
    assign sdi_s     = pipe[LAST].sdi;

endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
module spi_frame_ctrl
    import spi_acc_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                csn_act,
    input  logic                sclk_rise,
    input  logic                sdi,
    output frame_evt_t          evt,
    output logic [ADDR_W:0]     instr_word,
    output logic [DATA_W-1:0]   data_byte,
    output logic                in_read_data
);
    localparam int INSTR_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(INSTR_W);

    phase_e              phase;
    logic [CNT_W-1:0]    cnt;
    logic [INSTR_W-1:0]  sh;
    logic                dir_read;

    always_ff @(posedge clk) begin
        evt <= '0;
        if (rst || !csn_act) begin
            phase    <= PH_INSTR;
            cnt      <= '0;
            sh       <= '0;
            dir_read <= 1'b0;
        end else if (sclk_rise) begin
            sh <= {sh[INSTR_W-2:0], sdi};
            if (phase == PH_INSTR) begin
                if (cnt == CNT_W'(INSTR_W - 1)) begin
                    phase          <= PH_DATA;
                    cnt            <= '0;
                    dir_read       <= sh[INSTR_W-2];
                    evt.instr_done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt == CNT_W'(DATA_W - 1)) begin
                    cnt           <= '0;
                    evt.byte_done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign instr_word   = sh;
    assign data_byte    = sh[DATA_W-1:0];
    assign in_read_data = dir_read && (phase == PH_DATA);

    // events only come from edges seen inside a frame
    assert_evt_in_frame_R1: assert property (@(posedge clk) disable iff (rst)
        (evt.instr_done || evt.byte_done) |-> $past(csn_act))
        else $error("event raised outside a frame");

    assert_byte_spacing_R12: assert property (@(posedge clk) disable iff (rst)
        evt.byte_done |=> !evt.byte_done)
        else $error("back-to-back byte events");

endmodule

// File: rtl/spi_addr_seq.sv
`timescale 1ns/1ps
module spi_addr_seq
    import spi_acc_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  frame_evt_t          evt,
    input  logic [ADDR_W:0]     instr_word,
    input  logic [DATA_W-1:0]   data_byte,
    input  logic                in_read_data,
    input  logic                cfg_descend,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [DATA_W-1:0]   reg_wdata,
    output logic                reg_wr,
    output logic                reg_rd
);
    logic [ADDR_W-1:0] addr_step;

    // natural wrap modulo 2^ADDR_W
    assign addr_step = cfg_descend ? reg_addr - 1'b1 : reg_addr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (evt.instr_done) begin
                reg_addr <= instr_word[ADDR_W-1:0];
                reg_rd   <= instr_word[ADDR_W];
            end else if (evt.byte_done) begin
                if (in_read_data) begin
                    reg_addr <= addr_step;
                    reg_rd   <= 1'b1;
                end else begin
                    reg_wdata <= data_byte;
                    reg_wr    <= 1'b1;
                end
            end else if (reg_wr) begin
                reg_addr <= addr_step;
            end
        end
    end

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd))
        else $error("write and read strobes together");

    assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr)
        else $error("write strobe longer than one cycle");

    assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd)
        else $error("read strobe longer than one cycle");

    assert_addr_step_R10: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_addr == ($past(cfg_descend) ? $past(reg_addr) - 1'b1
                                                    : $past(reg_addr) + 1'b1)))
        else $error("address did not step after a write");

endmodule

// File: rtl/spi_tx_shifter.sv
`timescale 1ns/1ps
module spi_tx_shifter
    import spi_acc_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_act,
    input  logic              sclk_fall,
    input  logic              in_read_data,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              tx_bit,
    output logic              drive_en
);
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || !csn_act) begin
            sh       <= '0;
            tx_bit   <= 1'b0;
            drive_en <= 1'b0;
        end else if (load) begin
            sh <= load_data;
        end else if (sclk_fall && in_read_data) begin
            tx_bit   <= sh[DATA_W-1];
            sh       <= {sh[DATA_W-2:0], 1'b0};
            drive_en <= 1'b1;
        end
    end

    // the fetch must have landed before the edge that shifts it out
    assert_fetch_done_R5: assert property (@(posedge clk) disable iff (rst)
        (sclk_fall && in_read_data) |-> !load)
        else $error("register fetch collided with an output edge");

    assert_tx_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (drive_en && csn_act && !sclk_fall) |=> ($stable(tx_bit) || !csn_act))
        else $error("output bit moved without a falling serial edge");

endmodule

// File: rtl/spi_reg_access.sv
`timescale 1ns/1ps
module spi_reg_access
    import spi_acc_pkg::*;
#(
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_four_wire,
    input  logic              cfg_descend,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic              sclk_rise, sclk_fall, csn_act, sdi_s;
    frame_evt_t        evt;
    logic [ADDR_W:0]   instr_word;
    logic [DATA_W-1:0] data_byte;
    logic              in_read_data;
    logic              tx_bit, drive_en;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_i(spi_sclk), .csn_i(spi_csn), .sdi_i(sdio_i),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .csn_act(csn_act), .sdi_s(sdi_s)
    );

    spi_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst(rst),
        .csn_act(csn_act), .sclk_rise(sclk_rise), .sdi(sdi_s),
        .evt(evt), .instr_word(instr_word), .data_byte(data_byte),
        .in_read_data(in_read_data)
    );

    spi_addr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk(clk), .rst(rst),
        .evt(evt), .instr_word(instr_word), .data_byte(data_byte),
        .in_read_data(in_read_data), .cfg_descend(cfg_descend),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd)
    );

    spi_tx_shifter #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst(rst),
        .csn_act(csn_act), .sclk_fall(sclk_fall),
        .in_read_data(in_read_data),
        .load(reg_rd), .load_data(reg_rdata),
        .tx_bit(tx_bit), .drive_en(drive_en)
    );

    assign sdio_o  = tx_bit;
    assign sdo_o   = tx_bit;
    assign sdio_oe = drive_en && !cfg_four_wire;
    assign sdo_oe  = drive_en &&  cfg_four_wire;

    assert_oe_read_only_R9: assert property (@(posedge clk) disable iff (rst)
        (sdio_oe || sdo_oe) |-> in_read_data)
        else $error("driver enabled outside a read data phase");

    assert_wr_not_read_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> !drive_en)
        else $error("write strobe while output is driven");

endmodule

// File: tb/spi_reg_access_test.sv
`timescale 1ns/1ps
module spi_reg_access_test;

    localparam int HALF = 8;   // clk cycles per serial half period

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_four_wire = 1'b0;
    logic        cfg_descend = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_csn = 1'b1;
    logic        sdio_i = 1'b0;
    logic        sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [14:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_rdata;

    always #2.5 clk = ~clk;

    spi_reg_access uut (
        .clk(clk), .rst(rst),
        .cfg_four_wire(cfg_four_wire), .cfg_descend(cfg_descend),
        .spi_sclk(spi_sclk), .spi_csn(spi_csn),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] model(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    function automatic logic [14:0] addr_at(input logic [14:0] a, input logic desc, input int k);
        return desc ? a - 15'(k) : a + 15'(k);
    endfunction

    assign reg_rdata = model(reg_addr);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // register-side monitor
    logic [14:0] wr_addr [64];
    logic [7:0]  wr_data [64];
    logic [14:0] rd_addr [64];
    int nwr = 0, nrd = 0, clash = 0, wide = 0, oe_bad = 0;
    logic prev_wr = 1'b0, prev_rd = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr && nwr < 64) begin wr_addr[nwr] = reg_addr; wr_data[nwr] = reg_wdata; end
            if (reg_wr) nwr++;
            if (reg_rd && nrd < 64) rd_addr[nrd] = reg_addr;
            if (reg_rd) nrd++;
            if (reg_wr && reg_rd) clash++;
            if ((reg_wr && prev_wr) || (reg_rd && prev_rd)) wide++;
            prev_wr = reg_wr;
            prev_rd = reg_rd;
        end
    end

    logic [7:0] rx [16];

    task automatic sclk_bit(input logic b, input logic rd_phase, input logic four, output logic got);
        sdio_i = b;
        repeat (HALF) @(negedge clk);
        got = four ? sdo_o : sdio_o;
        if (sdio_oe !== (rd_phase && !four) || sdo_oe !== (rd_phase && four)) oe_bad++;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic xfer(input logic rd, input logic four, input logic desc,
                        input logic [14:0] a, input int nbytes, input logic [7:0] wbase,
                        input int tail_bits);
        logic        g;
        logic [15:0] ins;
        cfg_four_wire = four;
        cfg_descend   = desc;
        nwr = 0; nrd = 0; oe_bad = 0;
        ins = {rd, a};
        @(negedge clk) spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 15; i >= 0; i--) sclk_bit(ins[i], 1'b0, four, g);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] w;
            logic [7:0] r;
            w = wbase + 8'(b * 17);
            for (int i = 7; i >= 0; i--) begin
                sclk_bit(w[i], rd, four, g);
                r[i] = g;
            end
            rx[b] = r;
        end
        for (int i = 0; i < tail_bits; i++) sclk_bit(1'b1, rd, four, g);
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    // {rd, four_wire, descend, addr[14:0], nbytes[3:0]}
    localparam logic [21:0] VECS [0:7] = '{
        {1'b0, 1'b0, 1'b0, 15'h1234, 4'd1},
        {1'b1, 1'b0, 1'b0, 15'h1234, 4'd1},
        {1'b1, 1'b1, 1'b0, 15'h0456, 4'd3},
        {1'b0, 1'b1, 1'b1, 15'h2001, 4'd3},
        {1'b0, 1'b0, 1'b0, 15'h7FFE, 4'd3},
        {1'b1, 1'b0, 1'b1, 15'h0001, 4'd3},
        {1'b1, 1'b1, 1'b1, 15'h5A5A, 4'd2},
        {1'b0, 1'b0, 1'b1, 15'h0000, 4'd2}
    };

    task automatic finish_run();
        if (clash != 0 || wide != 0) begin
            checks++;
            errors++;
            $display("FAIL R12 strobe overlap/width actual=%0d expected=0", clash + wide);
        end else checks++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13: reset state
        chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R13 strobes", int'({reg_wr, reg_rd}), 0);
        chk(sdio_oe == 1'b0 && sdo_oe == 1'b0, "R13 enables", int'({sdio_oe, sdo_oe}), 0);

        // table of transactions
        for (int v = 0; v < 8; v++) begin
            logic        rd, four, desc;
            logic [14:0] a;
            int          nb;
            logic [7:0]  wb;
            {rd, four, desc, a} = VECS[v][21:4];
            nb = int'(VECS[v][3:0]);
            wb = a[7:0] ^ 8'hC3;
            xfer(rd, four, desc, a, nb, wb, 0);
            if (!rd) begin
                chk(nwr == nb, "R3 write count", nwr, nb);
                chk(nrd == 0, "R3 no read strobe", nrd, 0);
                chk(wr_addr[0] == a, "R2 first address", int'(wr_addr[0]), int'(a));
                for (int k = 0; k < nb; k++) begin
                    chk(wr_addr[k] == addr_at(a, desc, k), "R10 R11 write address",
                        int'(wr_addr[k]), int'(addr_at(a, desc, k)));
                    chk(wr_data[k] == wb + 8'(k * 17), "R3 write data",
                        int'(wr_data[k]), int'(wb + 8'(k * 17)));
                end
                chk(oe_bad == 0, "R9 enables in write", oe_bad, 0);
            end else begin
                chk(nrd == nb + 1, "R10 read strobes incl prefetch", nrd, nb + 1);
                chk(nwr == 0, "R5 no write strobe", nwr, 0);
                chk(rd_addr[0] == a, "R5 fetch address", int'(rd_addr[0]), int'(a));
                for (int k = 0; k < nb; k++) begin
                    chk(rd_addr[k] == addr_at(a, desc, k), "R10 R11 read address",
                        int'(rd_addr[k]), int'(addr_at(a, desc, k)));
                    chk(rx[k] == model(addr_at(a, desc, k)), "R6 read data",
                        int'(rx[k]), int'(model(addr_at(a, desc, k))));
                end
                chk(oe_bad == 0, four ? "R8 pin enables" : "R7 pin enables", oe_bad, 0);
            end
        end

        // R1: clock activity with select high
        nwr = 0; nrd = 0; oe_bad = 0;
        for (int i = 0; i < 40; i++) begin
            sdio_i = i[0];
            spi_sclk = ~spi_sclk;
            repeat (HALF) @(negedge clk);
            if (sdio_oe || sdo_oe) oe_bad++;
        end
        spi_sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        chk(nwr == 0 && nrd == 0, "R1 strobes while deselected", nwr + nrd, 0);
        chk(oe_bad == 0, "R1 enables while deselected", oe_bad, 0);

        // R4: partial trailing byte after a full one
        xfer(1'b0, 1'b0, 1'b0, 15'h0100, 1, 8'h96, 5);
        chk(nwr == 1, "R4 only full byte written", nwr, 1);
        chk(wr_data[0] == 8'h96, "R4 full byte data", int'(wr_data[0]), 8'h96);

        // R4: seven bits only
        xfer(1'b0, 1'b1, 1'b0, 15'h0200, 0, 8'h00, 7);
        chk(nwr == 0, "R4 partial byte discarded", nwr, 0);

        done = 1'b1;
        finish_run();
    end

endmodule